// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block brings an audio codec out of power-down after the chip resets, with no software involved. It switches on codec power and the output amplifier, releases mute and selects the 44.1 kHz sample clock. It holds the codec in hardware reset through a settling delay, releases it, and waits a second delay. It then loads the codec's registers over a serial control bus.

The block does not drive the control bus itself. It hands each transfer to a separate bus master through a request/done handshake, presenting a command byte, one or two payload bytes and a byte count. There are 13 transfers in a fixed order. The first is a status write with the soft-reset bit set. A hardware reset pulse follows, and the status register is then written again with reset cleared. Next come the remaining status, volume and tone writes, and finally six two-byte writes to the extended registers.

Once the bus master reports the last transfer as done, `ready_o` rises and stays high until the next reset. Delays are parameterised by clock frequency in kHz and delay length in ms, so a bench can shrink them. The delay in cycles is `DLY_CYC = CLK_KHZ * DELAY_MS`.

Top module: `codec_boot_seq`

## Requirements
- R1: While `rst_ni` is low: `pwr_en_o`=0, `amp_en_o`=0, `codec_rst_no`=0, `mute_o`=1, `clk_sel_o`=0, `req_o`=0, `ready_o`=0. A reset at any point restarts the sequence from transfer 0.
- R2: From the first clock after reset release, `pwr_en_o`=1, `amp_en_o`=1, `mute_o`=0 and `clk_sel_o`=2'b01 (44.1 kHz code). `codec_rst_no` stays low for at least `DLY_CYC` cycles.
- R3: After `codec_rst_no` rises, `req_o` stays low for at least `DLY_CYC` cycles. `req_o` is never high while `codec_rst_no` is low.
- R4: Once `req_o` is high, it holds with `cmd_o`, `len_o`, `d0_o` and `d1_o` stable until `done_i` is sampled high. `req_o` is low in the following cycle. A `done_i` while `req_o` is low is ignored.
- R5: Transfer 0 has command `{DEV_ADDR,2'b10}` (status type), `len_o`=1 and `d0_o`=8'h66. In that byte, bit 6 is soft reset, bits 5:4=2'b10 select a 256x system clock, and bits 3:1=3'b011 select 16-bit LSB-justified input.
- R6: After transfer 0 completes, `codec_rst_no` goes low for at least `PULSE_CYC` cycles. It then returns high for at least one cycle before transfer 1 is requested.
- R7: Transfers 1 and 2 are status writes of 8'h26 (transfer 0 with bit 6 cleared). Transfer 3 is a status write of 8'hE0, which sets bit 7, the output gain switch (bit 6) and the input gain switch (bit 5).
- R8: Transfers 4, 5 and 6 use command `{DEV_ADDR,2'b00}` (data type) with `len_o`=1, in this order:
  - 8'h00: volume field bits 5:0 = 0 attenuation, i.e. full volume.
  - 8'h40: bits 7:6=01, bass and treble 0.
  - 8'hA0: bits 7:6=10, peak-detect position bit 5 set.
- R9: Transfers 7 to 12 are data-type writes with `len_o`=2. For extended register n=0..5, `d0_o`=8'hC0|n and `d1_o`=8'hE0|v, with v = 4, 4, 30, 0, 0, 0.
- R10: `ready_o` rises in the cycle after the done of transfer 12 and stays high. No further request is made.
- R11: On every single-byte transfer, `d1_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Bus master reports the current transfer finished |
| req_o | output | 1 | Transfer request to the bus master |
| cmd_o | output | 8 | Command byte: device address and register type |
| len_o | output | 2 | Number of payload bytes (1 or 2) |
| d0_o | output | 8 | First payload byte |
| d1_o | output | 8 | Second payload byte (0 when `len_o`=1) |
| pwr_en_o | output | 1 | Codec power enable |
| amp_en_o | output | 1 | Amplifier enable |
| codec_rst_no | output | 1 | Codec hardware reset, active low |
| mute_o | output | 1 | Mute, active high |
| clk_sel_o | output | 2 | Sample-clock select (2'b01 = 44.1 kHz) |
| ready_o | output | 1 | Configuration complete |

## Verification
The bench goes after the interleaving around the first transfer: a hardware reset pulse must sit between transfer 0 and its repeat. A design that skipped the pulse, or that raised `req_o` while the codec was still in reset, would show `req_o` high with `codec_rst_no` low, or a pulse shorter than `PULSE_CYC`. Random done latencies and stray `done_i` pulses during the power delays probe the handshake. A design that took an early done would skip or reorder transfers, and one that changed bytes mid-request would break the stability checks. A reset in the middle of the sequence checks that the design restarts from transfer 0 rather than resuming. The bench also checks the extended-register bytes one at a time, so a wrong value code, address field or byte count is caught on the exact transfer where it occurs.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_PWR, ST_WAKE, ST_REQ, ST_GAP, ST_PULSE, ST_READY
  } boot_st_e;

  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] len;
    logic [7:0] d0;
    logic [7:0] d1;
  } xfer_t;

  localparam int unsigned NUM_XFER  = 13;
  localparam int unsigned FIRST_EXT = 7;

  localparam logic [1:0] TYPE_DATA = 2'b00;
  localparam logic [1:0] TYPE_STAT = 2'b10;

  localparam logic [7:0] STAT0_RST = 8'h40;
  localparam logic [7:0] STAT0_CFG = 8'h26;  // 256x sysclk, 16-bit LSB justified
  localparam logic [7:0] STAT1_CFG = 8'hE0;
  localparam logic [7:0] DAT_VOL   = 8'h00;
  localparam logic [7:0] DAT_TONE  = 8'h40;
  localparam logic [7:0] DAT_PEAK  = 8'hA0;
  localparam logic [7:0] EXT_ADDR  = 8'hC0;
  localparam logic [7:0] EXT_DATA  = 8'hE0;

  localparam logic [1:0] CLK_SEL_44K1 = 2'b01;

  function automatic logic [4:0] ext_val(input int unsigned n);
    case (n)
      0, 1:    ext_val = 5'd4;
      2:       ext_val = 5'd30;
      default: ext_val = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/codec_boot_timer.sv
module codec_boot_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/codec_boot_rom.sv
module codec_boot_rom
  import codec_boot_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR = 6'h05,
  parameter int unsigned IDX_W    = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output xfer_t            xfer_o
);
  localparam logic [7:0] CMD_STAT = {DEV_ADDR, TYPE_STAT};
  localparam logic [7:0] CMD_DATA = {DEV_ADDR, TYPE_DATA};

  xfer_t tbl [NUM_XFER];

  assign tbl[0] = '{cmd: CMD_STAT, len: 2'd1, d0: STAT0_CFG | STAT0_RST, d1: 8'h00};
  assign tbl[1] = '{cmd: CMD_STAT, len: 2'd1, d0: STAT0_CFG, d1: 8'h00};
  assign tbl[2] = '{cmd: CMD_STAT, len: 2'd1, d0: STAT0_CFG, d1: 8'h00};
  assign tbl[3] = '{cmd: CMD_STAT, len: 2'd1, d0: STAT1_CFG, d1: 8'h00};
  assign tbl[4] = '{cmd: CMD_DATA, len: 2'd1, d0: DAT_VOL,   d1: 8'h00};
  assign tbl[5] = '{cmd: CMD_DATA, len: 2'd1, d0: DAT_TONE,  d1: 8'h00};
  assign tbl[6] = '{cmd: CMD_DATA, len: 2'd1, d0: DAT_PEAK,  d1: 8'h00};

  for (genvar n = 0; n < NUM_XFER - FIRST_EXT; n++) begin : g_ext
    assign tbl[FIRST_EXT+n] = '{cmd: CMD_DATA, len: 2'd2,
                                d0: EXT_ADDR | 8'(n),
                                d1: EXT_DATA | {3'b000, ext_val(n)}};
  end

  always_comb begin
    xfer_o = tbl[0];
    for (int i = 0; i < NUM_XFER; i++)
      if (idx_i == IDX_W'(i)) xfer_o = tbl[i];
  end
endmodule

// File: rtl/codec_boot_fsm.sv
module codec_boot_fsm
  import codec_boot_pkg::*;
#(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DLY_CYC   = 100,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             tmr_exp_i,
  output boot_st_e         state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_XFER - 1);

  boot_st_e         state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    load_o     = 1'b0;
    load_val_o = CNT_W'(DLY_CYC);
    unique case (state_q)
      ST_OFF: begin
        load_o  = 1'b1;
        state_d = ST_PWR;
      end
      ST_PWR: if (tmr_exp_i) begin
        load_o  = 1'b1;
        state_d = ST_WAKE;
      end
      ST_WAKE: if (tmr_exp_i) state_d = ST_REQ;
      ST_REQ: if (done_i) begin
        if (idx_q == '0) begin
          load_o     = 1'b1;
          load_val_o = CNT_W'(PULSE_CYC);
          state_d    = ST_PULSE;
        end else if (idx_q == LAST_IDX) begin
          state_d = ST_READY;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_PULSE: if (tmr_exp_i) begin
        idx_d   = IDX_W'(1);
        state_d = ST_GAP;
      end
      ST_GAP:   state_d = ST_REQ;
      ST_READY: state_d = ST_READY;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import codec_boot_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 250000,
  parameter int unsigned DELAY_MS  = 100,
  parameter int unsigned PULSE_CYC = 4,
  parameter logic [5:0]  DEV_ADDR  = 6'h05
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  output logic       req_o,
  output logic [7:0] cmd_o,
  output logic [1:0] len_o,
  output logic [7:0] d0_o,
  output logic [7:0] d1_o,
  output logic       pwr_en_o,
  output logic       amp_en_o,
  output logic       codec_rst_no,
  output logic       mute_o,
  output logic [1:0] clk_sel_o,
  output logic       ready_o
);
  localparam int unsigned DLY_CYC = CLK_KHZ * DELAY_MS;
  localparam int unsigned MAX_CYC = (DLY_CYC > PULSE_CYC) ? DLY_CYC : PULSE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned IDX_W   = $clog2(NUM_XFER);

  boot_st_e         state;
  logic [IDX_W-1:0] idx;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  xfer_t            xfer;

  codec_boot_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .expired_o(tmr_exp)
  );

  codec_boot_fsm #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .DLY_CYC(DLY_CYC), .PULSE_CYC(PULSE_CYC)
  ) i_fsm (
    .clk_i, .rst_ni, .done_i, .tmr_exp_i(tmr_exp),
    .state_o(state), .idx_o(idx), .load_o(tmr_load), .load_val_o(tmr_val)
  );

  codec_boot_rom #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) i_rom (
    .idx_i(idx), .xfer_o(xfer)
  );

  logic powered;
  assign powered      = (state != ST_OFF);
  assign pwr_en_o     = powered;
  assign amp_en_o     = powered;
  assign mute_o       = !powered;
  assign clk_sel_o    = powered ? CLK_SEL_44K1 : 2'b00;
  assign codec_rst_no = !(state inside {ST_OFF, ST_PWR, ST_PULSE});
  assign req_o        = (state == ST_REQ);
  assign ready_o      = (state == ST_READY);
  assign cmd_o        = xfer.cmd;
  assign len_o        = xfer.len;
  assign d0_o         = xfer.d0;
  assign d1_o         = xfer.d1;
endmodule

// File: rtl/codec_boot_chk.sv
module codec_boot_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_i,
  input logic       req_o,
  input logic [7:0] cmd_o,
  input logic [1:0] len_o,
  input logic [7:0] d0_o,
  input logic [7:0] d1_o,
  input logic       codec_rst_no,
  input logic       ready_o
);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !done_i |=> req_o && $stable(cmd_o) && $stable(len_o)
                         && $stable(d0_o) && $stable(d1_o));
  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && done_i |=> !req_o);
  // R3
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !codec_rst_no |-> !req_o);
  // R10
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o && !req_o);
  // R9
  len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (len_o == 2'd1 || len_o == 2'd2));
  // R11
  single_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && len_o == 2'd1 |-> d1_o == 8'h00);
endmodule

bind codec_boot_seq codec_boot_chk i_codec_boot_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .req_o(req_o),
  .cmd_o(cmd_o), .len_o(len_o), .d0_o(d0_o), .d1_o(d1_o),
  .codec_rst_no(codec_rst_no), .ready_o(ready_o)
);

// File: tb/test_codec_boot_seq.sv
module test_codec_boot_seq;
  localparam int unsigned CLK_KHZ = 1, DELAY_MS = 20, PULSE_CYC = 3;
  localparam int unsigned DLY = CLK_KHZ * DELAY_MS;
  localparam logic [5:0]  DEV = 6'h05;

  logic clk_i = 1'b0, rst_ni = 1'b0, done_i = 1'b0;
  logic req_o, pwr_en_o, amp_en_o, codec_rst_no, mute_o, ready_o;
  logic [7:0] cmd_o, d0_o, d1_o;
  logic [1:0] len_o, clk_sel_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  codec_boot_seq #(.CLK_KHZ(CLK_KHZ), .DELAY_MS(DELAY_MS), .PULSE_CYC(PULSE_CYC),
                   .DEV_ADDR(DEV)) i_codec_boot_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected transfer {cmd,len,d0,d1} from the requirements
  function automatic logic [25:0] exp_xfer(input int idx);
    logic [7:0] st = {DEV, 2'b10}, dt = {DEV, 2'b00};
    logic [4:0] ev [6] = '{5'd4, 5'd4, 5'd30, 5'd0, 5'd0, 5'd0};
    case (idx)
      0:       return {st, 2'd1, 8'h66, 8'h00};
      1, 2:    return {st, 2'd1, 8'h26, 8'h00};
      3:       return {st, 2'd1, 8'hE0, 8'h00};
      4:       return {dt, 2'd1, 8'h00, 8'h00};
      5:       return {dt, 2'd1, 8'h40, 8'h00};
      6:       return {dt, 2'd1, 8'hA0, 8'h00};
      default: return {dt, 2'd2, 8'hC0 | 8'(idx - 7), 8'hE0 | {3'b0, ev[idx-7]}};
    endcase
  endfunction

  task automatic chk_reset_state();
    chk("R1 pwr_en", pwr_en_o, 0);       chk("R1 amp_en", amp_en_o, 0);
    chk("R1 codec_rst_n", codec_rst_no, 0); chk("R1 mute", mute_o, 1);
    chk("R1 clk_sel", clk_sel_o, 0);     chk("R1 req", req_o, 0);
    chk("R1 ready", ready_o, 0);
  endtask

  // runs the sequence; stops after the done of transfer last_idx
  task automatic run_seq(input int last_idx);
    int n;
    logic [25:0] got, exp;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 pwr_en", pwr_en_o, 1);   chk("R2 amp_en", amp_en_o, 1);
    chk("R2 mute", mute_o, 0);       chk("R2 clk_sel", clk_sel_o, 2'b01);
    n = 0;
    while (!codec_rst_no) begin
      n++;
      if (req_o) chk("R3 req during reset", req_o, 0);
      done_i = ($urandom % 5 == 0);  // stray done, R4 says ignored
      @(negedge clk_i);
    end
    done_i = 1'b0;
    chk("R2 reset low cycles ok", n >= DLY, 1);
    n = 0;
    while (!req_o) begin
      n++;
      done_i = ($urandom % 5 == 0);
      @(negedge clk_i);
    end
    done_i = 1'b0;
    chk("R3 wake cycles ok", n >= DLY, 1);
    for (int idx = 0; idx <= last_idx; idx++) begin
      got = {cmd_o, len_o, d0_o, d1_o};
      repeat ($urandom % 4) begin
        @(negedge clk_i);
        chk("R4 req held", req_o, 1);
        chk("R4 bytes stable", {cmd_o, len_o, d0_o, d1_o}, got);
      end
      exp = exp_xfer(idx);
      if (idx == 0)      chk("R5 xfer0", got, exp);
      else if (idx < 4)  chk("R7 status xfer", got, exp);
      else if (idx < 7)  chk("R8 data xfer", got, exp);
      else               chk("R9 ext xfer", got, exp);
      if (len_o == 2'd1) chk("R11 pad byte", d1_o, 0);
      done_i = 1'b1;
      @(negedge clk_i);
      done_i = 1'b0;
      chk("R4 req dropped", req_o, 0);
      if (idx == 0) begin
        n = 0;
        while (!codec_rst_no) begin
          n++;
          if (req_o) chk("R6 req in pulse", req_o, 0);
          @(negedge clk_i);
        end
        chk("R6 pulse width ok", n >= PULSE_CYC, 1);
        chk("R6 gap before xfer1", req_o, 0);
      end
      if (idx < last_idx) while (!req_o) @(negedge clk_i);
    end
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk_i);
    chk_reset_state();
    // partial run, then reset mid-sequence
    run_seq(5);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_reset_state();
    // full run must restart at transfer 0 (R1)
    run_seq(12);
    chk("R10 ready", ready_o, 1);
    repeat (10) begin
      done_i = $urandom % 2;
      @(negedge clk_i);
      chk("R10 ready held", ready_o, 1);
      chk("R10 no req", req_o, 0);
    end
    done_i = 1'b0;
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule